// File: doc/BRIEF.md
# Loopback Link Probe

This block exercises a data link that is wired back on itself and measures two figures from one payload. A generator sends a 16-bit word whose value climbs by one for every transfer the link accepts. The far end returns each word untouched. A receive monitor counts how many words come back within a fixed measuring window, and compares the first returning word of each window against the generator's present value to get the round-trip delay in clock counts. The data rate in bits per second is sixteen times the word count when the window lasts one second. The default window is 200,000,000 cycles, which is one second at 200 MHz. A delay of 20 counts at that clock is 0.1 µs.

Windows run back to back from reset. A window is `WINDOW` counting cycles, followed by one publish cycle. In the publish cycle the results change and `done` is high. A sequence monitor also flags any returning word that does not follow its predecessor.

The controller has four states. `ST_ARM` is the single cycle after reset and always goes to `ST_SEEK`. `ST_SEEK` is counting with no delay sample yet. It goes to `ST_TRACK` on a returning word, or to `ST_LATCH` on the last counting cycle. `ST_TRACK` is counting after the delay has been sampled, and goes to `ST_LATCH` on the last counting cycle. `ST_LATCH` is the publish cycle and always goes back to `ST_SEEK`.

Top module: `lnk_probe`

## Requirements
- R1: While `rst_n` is low, `tx_valid`, `done`, `seq_err`, `thr_words` and `lat_cnt` are all 0.
- R2: `tx_valid` is 1 from the first cycle after reset release. `tx_data` starts at 0 and rises by one, modulo 2^16, at each clock edge where `tx_valid` and `tx_ready` are both 1. At any other edge it holds its value.
- R3: `done` is high for exactly one cycle at a time. The first pulse comes `WINDOW`+1 cycles after reset release, and each later pulse comes `WINDOW`+1 cycles after the one before.
- R4: When `done` is high, `thr_words` equals the number of edges with `rx_valid`=1 among the `WINDOW` counting edges just before it. A word that arrives at the edge into the publish cycle is not counted in any window.
- R5: When `done` is high, `lat_cnt` equals (`tx_data` − `rx_data`) modulo 2^16, taken at the first edge of the window that has `rx_valid`=1. Later words in the same window do not change it.
- R6: A window with no returning word publishes `thr_words`=0 and `lat_cnt`=0.
- R7: `thr_words` and `lat_cnt` change only in cycles where `done` is high.
- R8: `seq_err` is 1 in the cycle after a returning word whose value is not the previous returning word plus one, modulo 2^16. The first word after reset never raises it. `rx_data` is ignored while `rx_valid` is 0. Words in the publish cycle are still checked.
- R9: A word arriving on the last counting edge is included in that window's count. If it is the window's first word, the delay is taken from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_ready | input | 1 | Link can take the transmit word this cycle |
| tx_valid | output | 1 | Transmit word offered |
| tx_data | output | 16 | Incrementing transmit payload |
| rx_valid | input | 1 | Returning word present |
| rx_data | input | 16 | Returning payload |
| thr_words | output | CNT_W (28 at default) | Words received in the last finished window |
| lat_cnt | output | 16 | Round-trip delay in clock counts, last finished window |
| done | output | 1 | One-cycle strobe when new results are published |
| seq_err | output | 1 | Previous returning word broke the +1 sequence |

## Verification
Two things can land on the same edge: the window closing and a word returning. When they coincide, the word must go into the count being published. If that word is also the window's first, the delay sample must be taken from it at the same moment. The bench provokes this with a directed phase that mutes the return path except on the last counting edge of each window. Random phases hit it by chance. At each `done`, the published count and delay are judged against a history that the bench keeps of every `rx_valid` it drove and every `tx_data`−`rx_data` gap it saw.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;
    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_SEEK  = 2'd1,
        ST_TRACK = 2'd2,
        ST_LATCH = 2'd3
    } lnk_state_t;
endpackage

// File: rtl/lnk_gen.sv
`timescale 1ns/1ps
module lnk_gen #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= 1'b1;
            if (tx_valid && tx_ready)
                tx_data <= tx_data + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_rxmon.sv
`timescale 1ns/1ps
module lnk_rxmon #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              seq_err
);
    logic              have_prev_q;
    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] want;

    assign want = prev_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            prev_q      <= '0;
            seq_err     <= 1'b0;
        end else begin
            seq_err <= rx_valid && have_prev_q && (rx_data != want);
            if (rx_valid) begin
                prev_q      <= rx_data;
                have_prev_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lnk_ctrl.sv
`timescale 1ns/1ps
module lnk_ctrl
    import lnk_pkg::*;
#(
    parameter int unsigned WINDOW = 200_000_000,
    parameter int          WORD_W = 16,
    parameter int          CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic [WORD_W-1:0] tx_data,
    output logic [CNT_W-1:0]  thr_words,
    output logic [WORD_W-1:0] lat_cnt,
    output logic              done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    lnk_state_t        st_q, st_d;
    logic [CNT_W-1:0]  wcnt_q;
    logic [CNT_W-1:0]  rxcnt_q;
    logic [WORD_W-1:0] lat_run_q;
    logic              counting;
    logic              win_last;
    logic              first_hit;
    logic [WORD_W-1:0] gap;
    logic [CNT_W-1:0]  rx_inc;

    assign counting  = (st_q == ST_SEEK) || (st_q == ST_TRACK);
    assign win_last  = counting && (wcnt_q == LAST);
    assign first_hit = (st_q == ST_SEEK) && rx_valid;
    assign gap       = tx_data - rx_data;
    assign rx_inc    = {{(CNT_W-1){1'b0}}, rx_valid};
    assign done      = (st_q == ST_LATCH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ARM;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ARM:   st_d = ST_SEEK;
            ST_SEEK:  begin
                if (win_last)      st_d = ST_LATCH;
                else if (rx_valid) st_d = ST_TRACK;
            end
            ST_TRACK: if (win_last) st_d = ST_LATCH;
            ST_LATCH: st_d = ST_SEEK;
            default:  st_d = ST_ARM;
        endcase
    end

    // counters and published results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q    <= '0;
            rxcnt_q   <= '0;
            lat_run_q <= '0;
            thr_words <= '0;
            lat_cnt   <= '0;
        end else begin
            unique case (st_q)
                ST_ARM, ST_LATCH: begin
                    wcnt_q    <= '0;
                    rxcnt_q   <= '0;
                    lat_run_q <= '0;
                end
                ST_SEEK, ST_TRACK: begin
                    wcnt_q  <= wcnt_q + 1'b1;
                    rxcnt_q <= rxcnt_q + rx_inc;
                    if (first_hit)
                        lat_run_q <= gap;
                    if (win_last) begin
                        thr_words <= rxcnt_q + rx_inc;
                        lat_cnt   <= first_hit ? gap : lat_run_q;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lnk_probe.sv
`timescale 1ns/1ps
module lnk_probe #(
    parameter int unsigned WINDOW = 200_000_000,
    parameter int          WORD_W = 16,
    localparam int         CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic [CNT_W-1:0]  thr_words,
    output logic [WORD_W-1:0] lat_cnt,
    output logic              done,
    output logic              seq_err
);
    lnk_gen #(.WORD_W(WORD_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    lnk_rxmon #(.WORD_W(WORD_W)) u_rxmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .seq_err  (seq_err)
    );

    lnk_ctrl #(.WINDOW(WINDOW), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_data   (tx_data),
        .thr_words (thr_words),
        .lat_cnt   (lat_cnt),
        .done      (done)
    );
endmodule

// File: rtl/lnk_probe_chk.sv
`timescale 1ns/1ps
module lnk_probe_chk #(
    parameter int unsigned WINDOW = 200_000_000,
    parameter int          WORD_W = 16,
    parameter int          CNT_W  = $clog2(WINDOW + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_ready,
    input logic              tx_valid,
    input logic [WORD_W-1:0] tx_data,
    input logic              rx_valid,
    input logic [CNT_W-1:0]  thr_words,
    input logic [WORD_W-1:0] lat_cnt,
    input logic              done,
    input logic              seq_err
);
    logic [CNT_W:0] gap_q;
    logic           seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (done) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_data == $past(tx_data)));
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (tx_data == WORD_W'($past(tx_data) + 1'b1)));
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (gap_q == (seen_q ? (CNT_W+1)'(WINDOW) : (CNT_W+1)'(WINDOW + 1))));
    a_r4_thr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        thr_words <= CNT_W'(WINDOW));
    a_r7_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(thr_words) |-> done);
    a_r7_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_cnt) |-> done);
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $past(rx_valid));
endmodule

bind lnk_probe lnk_probe_chk #(.WINDOW(WINDOW), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .thr_words (thr_words),
    .lat_cnt   (lat_cnt),
    .done      (done),
    .seq_err   (seq_err)
);

// File: tb/sim_lnk_probe.sv
`timescale 1ns/1ps
module sim_lnk_probe;
    localparam int unsigned W     = 64;
    localparam int          DELAY = 20;
    localparam int          CW    = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tx_ready;
    logic          tx_valid;
    logic [15:0]   tx_data;
    logic          rx_valid;
    logic [15:0]   rx_data;
    logic [CW-1:0] thr_words;
    logic [15:0]   lat_cnt;
    logic          done;
    logic          seq_err;

    always #2.5 clk = ~clk;

    lnk_probe #(.WINDOW(W), .WORD_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .thr_words(thr_words), .lat_cnt(lat_cnt), .done(done), .seq_err(seq_err)
    );

    int checks = 0;
    int errs   = 0;
    bit finished = 0;

    logic [15:0] dq_data[$];
    int          dq_due[$];
    bit          hv[$];
    logic [15:0] hd[$];

    int          cyc = 0;
    int          since = 0;
    int          mode = 0;
    logic [15:0] exp_tx = 0;
    bit          exp_seq = 0;
    bit          have_prev = 0;
    logic [15:0] prev_rx = 0;
    int          prev_thr = 0;
    logic [15:0] prev_lat = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_thr();
        int s = 0;
        foreach (hv[i]) s += hv[i];
        return s;
    endfunction

    function automatic logic [15:0] exp_lat();
        foreach (hv[i]) if (hv[i]) return hd[i];
        return 16'd0;
    endfunction

    function automatic bit first_is_last();
        foreach (hv[i]) if (hv[i]) return (i == hv.size() - 1);
        return 1'b0;
    endfunction

    task automatic sample();
        int          t;
        logic [15:0] l;
        since++;
        chk("R2 tx_valid", {31'd0, tx_valid}, 1);
        chk("R2 tx_data", {16'd0, tx_data}, {16'd0, exp_tx});
        chk("R8 seq_err", {31'd0, seq_err}, {31'd0, exp_seq});
        if (done) begin
            chk("R3 done spacing", since, W + 1);
            t = exp_thr();
            l = exp_lat();
            if (t == 0) begin
                chk("R6 empty thr", 32'(thr_words), 0);
                chk("R6 empty lat", {16'd0, lat_cnt}, 0);
            end else begin
                if (hv[hv.size()-1]) chk("R9 last-edge word counted", 32'(thr_words), t);
                else                 chk("R4 throughput", 32'(thr_words), t);
                if (first_is_last()) chk("R9 latency from last edge", {16'd0, lat_cnt}, {16'd0, l});
                else                 chk("R5 latency", {16'd0, lat_cnt}, {16'd0, l});
            end
            prev_thr = t;
            prev_lat = l;
            since = 0;
        end else begin
            chk("R3 done overdue", {31'd0, since > int'(W)}, 0);
            chk("R7 thr hold", 32'(thr_words), prev_thr);
            chk("R7 lat hold", {16'd0, lat_cnt}, {16'd0, prev_lat});
        end
    endtask

    task automatic drive();
        bit          acc;
        bit          ok;
        logic [15:0] d;
        cyc++;
        tx_ready = (mode == 2) ? 1'b0 : ($urandom % 4 != 0);
        acc = tx_valid && tx_ready;
        if (acc) begin
            dq_data.push_back(tx_data);
            dq_due.push_back(cyc + DELAY);
            exp_tx = exp_tx + 16'd1;
        end
        ok = (dq_data.size() > 0) && (dq_due[0] <= cyc);
        case (mode)
            0:       ok = ok && ($urandom % 5 < 3);
            1:       ok = 1'b0;
            3:       ok = ok && (since == int'(W));
            default: ;
        endcase
        if (ok) begin
            d = dq_data.pop_front();
            void'(dq_due.pop_front());
            if (mode == 0 && ($urandom % 30 == 0)) d = d ^ 16'h0100;
            rx_valid = 1'b1;
            rx_data  = d;
        end else begin
            rx_valid = 1'b0;
            rx_data  = 16'($urandom);
        end
        hv.push_back(rx_valid);
        hd.push_back(tx_data - rx_data);
        if (hv.size() > int'(W)) begin
            void'(hv.pop_front());
            void'(hd.pop_front());
        end
        exp_seq = rx_valid && have_prev && (rx_data != prev_rx + 16'd1);
        if (rx_valid) begin
            prev_rx   = rx_data;
            have_prev = 1'b1;
        end
    endtask

    task automatic run(input int m, input int n);
        mode = m;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sample();
            drive();
        end
    endtask

    initial begin
        void'($urandom(32'h1d2c));
        rst_n    = 1'b0;
        tx_ready = 1'b0;
        rx_valid = 1'b0;
        rx_data  = 16'h0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R1 tx_valid", {31'd0, tx_valid}, 0);
            chk("R1 done", {31'd0, done}, 0);
            chk("R1 seq_err", {31'd0, seq_err}, 0);
            chk("R1 thr", 32'(thr_words), 0);
            chk("R1 lat", {16'd0, lat_cnt}, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        drive();
        run(0, 8 * (W + 1));
        run(2, 30);
        run(1, 2 * (W + 1) + 4);
        run(0, 2 * (W + 1));
        run(3, 3 * (W + 1));
        run(0, 3 * (W + 1));
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL R3 watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end
endmodule